// File: doc/BRIEF.md
# Channel Waveform Overlay Generator

This block sits in front of one converter channel's output register. On every accepted trigger it takes the channel's held 12-bit code, adds a generated component to it, and registers the result as the new output code. The generated component is either nothing, a masked pseudo-random value, or a value from a triangle counter, depending on a mode setting.

A single 4-bit amplitude setting shapes the component in both active modes. In noise mode it sets how many low bits of the pseudo-random word are kept. In triangle mode it sets the turning point of the counter. Mode and amplitude are captured only while the channel is off, so they cannot change while it runs. Turning the channel off also returns both generators to their start state.

Top module: `dac_wavegen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_code` becomes 0 and the captured configuration becomes mode off with amplitude 0.
- R2: `out_code` changes only at a rising edge where `chan_en` and `trig` are both high. A trigger while the channel is off is ignored.
- R3: Mode encoding on `wave_mode`: 2'b00 off, 2'b01 noise, 2'b10 or 2'b11 triangle. In off mode an accepted trigger loads `out_code` with `hold_code` unchanged.
- R4: In noise mode the source is a 12-bit shift register holding 12'hACE at start. On each accepted trigger the masked value is added using the word as it stands before the step. The word then shifts left by one, and the new bit 0 is the XOR of bits 11, 10, 9 and 3.
- R5: In noise mode, for an effective amplitude n, the low n+1 bits of the shift-register word are kept and the rest are zeroed.
- R6: In triangle mode the counter starts at 0 and its current value is added on each accepted trigger. It then steps by one toward the peak and reverses at the peak and at 0, giving 0,1,..,peak,..,1,0,1,...
- R7: The triangle peak for an effective amplitude n is 2^(n+1)-1, so the default amplitude 0 gives a peak of 1.
- R8: An amplitude setting above 11 acts as 11.
- R9: The sum of `hold_code` and the generated value wraps modulo 4096 and does not saturate.
- R10: `wave_mode` and `amp_sel` are captured at each rising edge where `chan_en` is low. Changes while the channel is on have no effect.
- R11: At each rising edge where `chan_en` is low, the shift register returns to 12'hACE and the triangle counter returns to 0, counting up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_en | input | 1 | Channel on; freezes the configuration and lets the generators run |
| wave_mode | input | 2 | Overlay mode request |
| amp_sel | input | 4 | Amplitude request (mask width or triangle peak) |
| trig | input | 1 | Trigger strobe, one step per high cycle |
| hold_code | input | 12 | Held code that the overlay is added to |
| out_code | output | 12 | Registered output code |

## Verification
Every result of an accepted trigger appears one rising edge later, because `out_code` is the only register between the trigger and the port. Configuration and generator restart also take effect at the edge that samples `chan_en` low. The bench drives inputs on falling edges and compares `out_code` with its own behavioural model at the following falling edge, one full edge after the stimulus. The directed checks wait exactly one rising edge after each trigger cycle before comparing against hand-computed values.

// File: rtl/dac_wavegen_pkg.sv
// Shared types for the channel waveform overlay generator.
// Assumes a 2-bit mode request; both upper encodings select the triangle.
package dac_wavegen_pkg;

    typedef enum logic [1:0] {
        WG_OFF     = 2'b00,
        WG_NOISE   = 2'b01,
        WG_TRI     = 2'b10,
        WG_TRI_ALT = 2'b11
    } wg_mode_e;

endpackage

// File: rtl/wg_cfg_lock.sv
// Configuration capture: records mode and amplitude while the channel is
// off and holds them while it is on. The amplitude is clamped to DATA_W-1
// on capture. Assumes AMP_W is wide enough to hold DATA_W-1.
module wg_cfg_lock
    import dac_wavegen_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic [1:0]       mode_in,
    input  logic [AMP_W-1:0] amp_in,
    output wg_mode_e         mode_q,
    output logic [AMP_W-1:0] amp_q
);
    localparam logic [AMP_W-1:0] AMP_CAP = AMP_W'(DATA_W - 1);

    logic [AMP_W-1:0] amp_clamped;

    // Limit the requested amplitude to the data width.
    always_comb begin
        amp_clamped = (amp_in > AMP_CAP) ? AMP_CAP : amp_in;
    end

    // Capture the settings only while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WG_OFF;
            amp_q  <= '0;
        end else if (!chan_en) begin
            mode_q <= wg_mode_e'(mode_in);
            amp_q  <= amp_clamped;
        end
    end

    p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && $past(chan_en)) |-> ($stable(mode_q) && $stable(amp_q)));

    p_amp_capped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        amp_q <= AMP_CAP);

endmodule

// File: rtl/wg_noise.sv
// Pseudo-random overlay source: a Fibonacci shift register that steps once
// per accepted trigger in noise mode. It returns to SEED while the channel
// is off. The output keeps the low amp+1 bits of the current word.
// Assumes SEED is nonzero and TAPS gives a maximal-length sequence.
module wg_noise #(
    parameter int              DATA_W = 12,
    parameter int              AMP_W  = 4,
    parameter logic [DATA_W-1:0] SEED = 12'hACE,
    parameter logic [DATA_W-1:0] TAPS = 12'hE08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              step,
    input  logic [AMP_W-1:0]  amp,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] lfsr_q;
    logic [DATA_W-1:0] keep_mask;
    logic              feedback;

    // Build the keep mask bit by bit from the amplitude.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign keep_mask[i] = (32'(amp) >= 32'(i));
    end

    // Feedback is the parity of the tapped bits.
    always_comb begin
        feedback = ^(lfsr_q & TAPS);
    end

    // Restart while off, shift once per step while on.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) begin
            lfsr_q <= SEED;
        end else if (step) begin
            lfsr_q <= {lfsr_q[DATA_W-2:0], feedback};
        end
    end

    assign value = lfsr_q & keep_mask;

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    p_lfsr_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chan_en) |-> (lfsr_q == SEED));

endmodule

// File: rtl/wg_triangle.sv
// Triangle overlay source: an up/down counter between 0 and 2^(amp+1)-1
// that steps once per accepted trigger in triangle mode. It returns to 0,
// counting up, while the channel is off. Assumes amp <= DATA_W-1, so the
// peak is at least 1 and the counter never stalls.
module wg_triangle #(
    parameter int DATA_W = 12,
    parameter int AMP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              step,
    input  logic [AMP_W-1:0]  amp,
    output logic [DATA_W-1:0] value
);
    logic [DATA_W-1:0] cnt_q;
    logic              rising_q;
    logic [DATA_W-1:0] peak;

    // The peak is a run of amp+1 ones from bit 0.
    for (genvar i = 0; i < DATA_W; i++) begin : g_peak
        assign peak[i] = (32'(amp) >= 32'(i));
    end

    // Restart while off, walk up and down once per step while on.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) begin
            cnt_q    <= '0;
            rising_q <= 1'b1;
        end else if (step) begin
            if (rising_q) begin
                if (cnt_q == peak) begin
                    rising_q <= 1'b0;
                    cnt_q    <= cnt_q - 1'b1;
                end else begin
                    cnt_q    <= cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == '0) begin
                    rising_q <= 1'b1;
                    cnt_q    <= cnt_q + 1'b1;
                end else begin
                    cnt_q    <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign value = cnt_q;

    p_tri_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= peak);

    p_tri_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chan_en) |-> (cnt_q == '0 && rising_q));

endmodule

// File: rtl/dac_wavegen.sv
// Channel waveform overlay generator top. On every trigger accepted while
// the channel is on, it adds the selected overlay to the held code and
// registers the wrapped sum as the output code.
// Assumes trig is a level sampled at each rising edge: one step per high cycle.
module dac_wavegen
    import dac_wavegen_pkg::*;
#(
    parameter int              DATA_W = 12,
    parameter int              AMP_W  = 4,
    parameter logic [DATA_W-1:0] SEED = 12'hACE,
    parameter logic [DATA_W-1:0] TAPS = 12'hE08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [1:0]        wave_mode,
    input  logic [AMP_W-1:0]  amp_sel,
    input  logic              trig,
    input  logic [DATA_W-1:0] hold_code,
    output logic [DATA_W-1:0] out_code
);
    wg_mode_e          mode_q;
    logic [AMP_W-1:0]  amp_q;
    logic              fire;
    logic              noise_on;
    logic              tri_on;
    logic [DATA_W-1:0] noise_val;
    logic [DATA_W-1:0] tri_val;
    logic [DATA_W-1:0] overlay;

    wg_cfg_lock #(.DATA_W(DATA_W), .AMP_W(AMP_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .mode_in (wave_mode),
        .amp_in  (amp_sel),
        .mode_q  (mode_q),
        .amp_q   (amp_q)
    );

    // A trigger counts only while the channel is on.
    always_comb begin
        fire     = chan_en && trig;
        noise_on = (mode_q == WG_NOISE);
        tri_on   = (mode_q == WG_TRI) || (mode_q == WG_TRI_ALT);
    end

    wg_noise #(.DATA_W(DATA_W), .AMP_W(AMP_W), .SEED(SEED), .TAPS(TAPS)) u_noise (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .step    (fire && noise_on),
        .amp     (amp_q),
        .value   (noise_val)
    );

    wg_triangle #(.DATA_W(DATA_W), .AMP_W(AMP_W)) u_tri (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .step    (fire && tri_on),
        .amp     (amp_q),
        .value   (tri_val)
    );

    // Pick the overlay that the captured mode selects.
    always_comb begin
        if (noise_on)    overlay = noise_val;
        else if (tri_on) overlay = tri_val;
        else             overlay = '0;
    end

    // Register the wrapped sum on each accepted trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_code <= '0;
        end else if (fire) begin
            out_code <= hold_code + overlay;
        end
    end

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fire) |-> $stable(out_code));

    p_off_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && mode_q == WG_OFF) |-> (out_code == $past(hold_code)));

    p_tri_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fire && tri_on) |-> (out_code == DATA_W'($past(hold_code) + $past(tri_val))));

endmodule

// File: tb/dac_wavegen_tb.sv
module dac_wavegen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [1:0]  wave_mode = 2'b00;
    logic [3:0]  amp_sel = 4'd0;
    logic        trig = 1'b0;
    logic [11:0] hold_code = 12'd0;
    logic [11:0] out_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // behavioural reference state
    int m_out = 0, m_lfsr = 'hACE, m_tri = 0, m_up = 1, m_mode = 0, m_amp = 0;

    dac_wavegen u_dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wave_mode(wave_mode),
        .amp_sel(amp_sel), .trig(trig), .hold_code(hold_code), .out_code(out_code)
    );

    always #10 clk = ~clk;

    // Reference model: updates at each rising edge from the driven inputs.
    always @(posedge clk) begin
        int wave, peak, fb;
        if (!rst_n) begin
            m_out = 0; m_lfsr = 'hACE; m_tri = 0; m_up = 1; m_mode = 0; m_amp = 0;
        end else if (!chan_en) begin
            m_mode = wave_mode;
            m_amp  = (amp_sel > 11) ? 11 : amp_sel;
            m_lfsr = 'hACE; m_tri = 0; m_up = 1;
        end else if (trig) begin
            peak = (1 << (m_amp + 1)) - 1;
            if (m_mode == 1)      wave = m_lfsr & peak;
            else if (m_mode >= 2) wave = m_tri;
            else                  wave = 0;
            m_out = (hold_code + wave) % 4096;
            if (m_mode == 1) begin
                fb = ((m_lfsr >> 11) ^ (m_lfsr >> 10) ^ (m_lfsr >> 9) ^ (m_lfsr >> 3)) & 1;
                m_lfsr = ((m_lfsr << 1) | fb) & 'hFFF;
            end else if (m_mode >= 2) begin
                if (m_up != 0) begin
                    if (m_tri == peak) begin m_up = 0; m_tri = m_tri - 1; end
                    else m_tri = m_tri + 1;
                end else begin
                    if (m_tri == 0) begin m_up = 1; m_tri = m_tri + 1; end
                    else m_tri = m_tri - 1;
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        total++;
        if (out_code !== 12'(m_out)) begin
            bad++;
            $display("FAIL R2/R3/R4/R6 model compare: actual=%h expected=%h", out_code, 12'(m_out));
        end
    end

    task automatic check(input logic [11:0] exp, input string req);
        total++;
        if (out_code !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, out_code, exp);
        end
    endtask

    // Hold the trigger high for one rising edge, then sample at the next falling edge.
    task automatic pulse(input logic [11:0] h);
        hold_code = h; trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Turn the channel off for one edge with a new setting, then back on.
    task automatic setup(input logic [1:0] md, input logic [3:0] am);
        chan_en = 1'b0; wave_mode = md; amp_sel = am;
        @(negedge clk);
        chan_en = 1'b1;
    endtask

    initial begin
        idle(3);
        check(12'h000, "R1 reset value");
        rst_n = 1'b1;
        idle(1);

        // R2: trigger while the channel is off is ignored
        pulse(12'h777);
        check(12'h000, "R2 trigger ignored while off");

        // R3: off mode passes the held code through
        setup(2'b00, 4'd5);
        pulse(12'h123);
        check(12'h123, "R3 off passthrough");
        idle(2);
        check(12'h123, "R2 no trigger keeps output");

        // R6/R7: amplitude 1 gives peak 3
        setup(2'b10, 4'd1);
        begin
            int seq[8] = '{0, 1, 2, 3, 2, 1, 0, 1};
            for (int i = 0; i < 8; i++) begin
                pulse(12'h100);
                check(12'(12'h100 + seq[i]), "R6 R7 triangle sequence");
            end
        end

        // R11 and R3 alternate encoding: re-enable restarts the counter at 0
        setup(2'b11, 4'd0);
        pulse(12'h200);
        check(12'h200, "R11 triangle restart");
        pulse(12'h200);
        check(12'h201, "R7 peak 1 with amplitude 0");

        // R10: settings changed while on have no effect
        wave_mode = 2'b00; amp_sel = 4'd3;
        pulse(12'h200);
        check(12'h200, "R10 locked mode down-step");
        pulse(12'h200);
        check(12'h201, "R10 locked peak");

        // R9: wrap around 4096
        setup(2'b10, 4'd0);
        pulse(12'hFFF);
        check(12'hFFF, "R9 first step");
        pulse(12'hFFF);
        check(12'h000, "R9 wrap to zero");

        // R4: noise with full width, start word then first shifted word
        setup(2'b01, 4'd11);
        pulse(12'h000);
        check(12'hACE, "R4 seed value");
        pulse(12'h000);
        check(12'h59D, "R4 first shift");

        // R5: amplitude 0 keeps only bit 0
        setup(2'b01, 4'd0);
        pulse(12'h010);
        check(12'h010, "R5 one-bit mask seed");
        pulse(12'h010);
        check(12'h011, "R5 one-bit mask step");

        // R8: amplitude 15 acts as 11
        setup(2'b01, 4'd15);
        pulse(12'h000);
        check(12'hACE, "R8 clamp seed");
        pulse(12'h000);
        check(12'h59D, "R8 clamp step");

        // Longer run of mixed patterns, checked by the model each cycle
        setup(2'b01, 4'd6);
        for (int i = 0; i < 200; i++) begin
            hold_code = 12'(i * 37);
            trig = (i % 3 != 0);
            @(negedge clk);
        end
        trig = 1'b0;
        setup(2'b10, 4'd3);
        for (int i = 0; i < 100; i++) begin
            hold_code = 12'(4000 + i);
            trig = (i % 2 == 0);
            @(negedge clk);
        end
        trig = 1'b0;
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule